// File: doc/BRIEF.md
# Low-Power Mode Sequencer for an 8-bit Controller Core

This block decides when an 8-bit controller core sleeps and when it wakes. Software asks for a low-power state by writing the power-control register at special-function address 87h. There are two states. In the light one the core clock stops while the peripheral clocks and the crystal amplifier keep running, so timers, watchdog, serial port and supply monitor keep working. In the deep one every on-chip clock is gated and the crystal amplifier is switched off.

Wake sources are filtered by mode. The light state ends on any enabled interrupt request. The deep state ends only on requests tagged as not needing a clock, or on the supply-fail request when the bandgap reference is on. After a deep wake the oscillator restarts, and the core clock stays gated for a fixed settle count before it is released. On every interrupt wake the block raises a one-cycle vector-fetch request carrying the number of the waking source and clears the mode bits. Any of the reset sources ends either state at once, holds the core in reset and returns all clocks.

Top module: `lpm_ctrl`

## Requirements
- R1: After the block reset, core_clk_en, periph_clk_en and osc_amp_en are 1, vec_fetch and core_rst are 0, and a read of address 87h returns 00h.
- R2: A write to 87h with data bit 0 set and bit 1 clear, made while the core runs, stores the light-state bit. From the second clock edge after the write, core_clk_en is 0 while periph_clk_en and osc_amp_en stay 1, and a read of 87h returns 01h.
- R3: A write to 87h with data bit 1 set stores the deep-state bit, whatever bit 0 holds. From the second edge after the write, all three clock enables are 0 and a read of 87h returns 02h.
- R4: In the light state, any set irq_req bit or pfail_irq (with or without bandgap_en) ends the state on the next edge. core_clk_en returns to 1, vec_fetch is 1 for exactly one cycle, wake_id gives the lowest set irq_req index (NIRQ for the supply-fail source when no irq_req bit is set), and the mode bits read back as 0.
- R5: In the deep state, irq_req bits whose irq_nonclk tag is 0 are not wake events: the block stays in the deep state with all enables 0.
- R6: In the deep state, pfail_irq wakes the block only while bandgap_en is 1. Its wake_id is NIRQ.
- R7: A deep-state wake sets osc_amp_en on the next edge and holds core_clk_en and periph_clk_en at 0 for WAKE_DLY cycles. Both enables return together with a one-cycle vec_fetch. wake_id gives the lowest set index among irq_req & irq_nonclk.
- R8: Any set rst_src bit, in any state, returns the block to running with all enables 1 and both mode bits cleared on the next edge, without a vec_fetch. core_rst follows the OR of rst_src one cycle later.
- R9: Writes to any address other than 87h, and writes of any address made while the core clock is gated, leave the mode bits unchanged.
- R10: sfr_rdata is registered. One edge after sfr_addr is 87h it shows {6'b0, deep bit, light bit}, and for any other address it shows 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rst | input | 1 | Synchronous active-high block reset |
| sfr_addr | input | 8 | Special-function register address |
| sfr_wr | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Registered read data |
| irq_req | input | NIRQ | Enabled interrupt requests |
| irq_nonclk | input | NIRQ | 1 marks a request that needs no clock to be raised |
| pfail_irq | input | 1 | Supply-fail interrupt request |
| bandgap_en | input | 1 | Bandgap reference is enabled |
| rst_src | input | NRST | Reset source requests |
| core_clk_en | output | 1 | CPU core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_amp_en | output | 1 | Crystal amplifier enable |
| core_rst | output | 1 | Reset held on the core |
| vec_fetch | output | 1 | One-cycle request to fetch the wake vector |
| wake_id | output | IDW | Number of the source that caused the wake |

## Verification
Mode entry is due on the second edge after the write strobe, because the mode bit and then the state register each take one edge. A light-state wake, a supply-fail wake that has been refused, and a reset-source exit all show on the first edge after the request. A deep wake returns the oscillator on the first edge and the core clock on edge WAKE_DLY+1, and read data trails the register by one edge. Inputs are driven on falling edges and outputs are sampled on the falling edge after the edge where each result is due. The bench also samples the cycle just before a due edge to show the result has not come early.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_STOP = 2'd2,
    PM_WARM = 2'd3
  } pm_state_t;

  localparam logic [7:0] PCON_ADDR = 8'h87;
  localparam int LIGHT_BIT = 0;
  localparam int DEEP_BIT  = 1;
endpackage

// File: rtl/lpm_modereg.sv
module lpm_modereg
  import lpm_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic          clr_i,
  input  logic [AW-1:0] sfr_addr,
  input  logic          sfr_wr,
  input  logic [DW-1:0] sfr_wdata,
  output logic [DW-1:0] sfr_rdata,
  output logic          light_q,
  output logic          deep_q
);
  localparam logic [AW-1:0] MY_ADDR = AW'(PCON_ADDR);

  logic          hit_w;
  logic          wr_ok;
  logic [DW-1:0] rd_w;
  logic          unused_hi;

  assign hit_w     = (sfr_addr == MY_ADDR);
  assign wr_ok     = run_i && sfr_wr && hit_w;
  assign unused_hi = ^sfr_wdata;

  always_comb begin
    rd_w = '0;
    if (hit_w) begin
      rd_w[LIGHT_BIT] = light_q;
      rd_w[DEEP_BIT]  = deep_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      light_q   <= 1'b0;
      deep_q    <= 1'b0;
      sfr_rdata <= '0;
    end else begin
      sfr_rdata <= rd_w;
      if (clr_i) begin
        light_q <= 1'b0;
        deep_q  <= 1'b0;
      end else if (wr_ok) begin
        deep_q  <= sfr_wdata[DEEP_BIT];
        light_q <= sfr_wdata[LIGHT_BIT] & ~sfr_wdata[DEEP_BIT];
      end
    end
  end

  assert_deep_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && !clr_i && sfr_wdata[DEEP_BIT]) |=> (deep_q && !light_q));

  assert_clear_bits_R8: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (!deep_q && !light_q));

  assert_gated_write_R9: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !clr_i) |=> ($stable(deep_q) && $stable(light_q)));
endmodule

// File: rtl/lpm_wakequal.sv
module lpm_wakequal #(
  parameter int NIRQ = 6,
  parameter int IDW  = 3
) (
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_nonclk,
  input  logic            pfail_irq,
  input  logic            bandgap_en,
  output logic            light_hit,
  output logic            deep_hit,
  output logic [IDW-1:0]  light_id,
  output logic [IDW-1:0]  deep_id
);
  localparam logic [IDW-1:0] PF_ID = IDW'(NIRQ);

  logic [NIRQ-1:0] quiet_req;
  logic            pf_ok;

  assign quiet_req = irq_req & irq_nonclk;
  assign pf_ok     = pfail_irq & bandgap_en;
  assign light_hit = (|irq_req) | pfail_irq;
  assign deep_hit  = (|quiet_req) | pf_ok;

  always_comb begin
    light_id = PF_ID;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (irq_req[i]) light_id = IDW'(i);
    end
  end

  always_comb begin
    deep_id = PF_ID;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (quiet_req[i]) deep_id = IDW'(i);
    end
  end
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int IDW      = 3,
  parameter int WAKE_DLY = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           light_q,
  input  logic           deep_q,
  input  logic           rst_any,
  input  logic           light_hit,
  input  logic           deep_hit,
  input  logic [IDW-1:0] light_id,
  input  logic [IDW-1:0] deep_id,
  output logic           clr_o,
  output logic           core_clk_en,
  output logic           periph_clk_en,
  output logic           osc_amp_en,
  output logic           core_rst,
  output logic           vec_fetch,
  output logic [IDW-1:0] wake_id
);
  localparam int CW = $clog2(WAKE_DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(WAKE_DLY - 1);

  pm_state_t     st_q;
  logic [CW-1:0] cnt_q;

  assign clr_o = rst_any
              || (st_q == PM_IDLE && light_hit)
              || (st_q == PM_STOP && deep_hit);

  assign core_clk_en   = (st_q == PM_RUN);
  assign periph_clk_en = (st_q == PM_RUN) || (st_q == PM_IDLE);
  assign osc_amp_en    = (st_q != PM_STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= PM_RUN;
      cnt_q     <= '0;
      vec_fetch <= 1'b0;
      wake_id   <= '0;
      core_rst  <= 1'b0;
    end else begin
      vec_fetch <= 1'b0;
      core_rst  <= rst_any;
      if (rst_any) begin
        st_q  <= PM_RUN;
        cnt_q <= '0;
      end else begin
        case (st_q)
          PM_RUN: begin
            if (deep_q) st_q <= PM_STOP;
            else if (light_q) st_q <= PM_IDLE;
          end
          PM_IDLE: begin
            if (light_hit) begin
              st_q      <= PM_RUN;
              vec_fetch <= 1'b1;
              wake_id   <= light_id;
            end
          end
          PM_STOP: begin
            if (deep_hit) begin
              st_q    <= PM_WARM;
              cnt_q   <= '0;
              wake_id <= deep_id;
            end
          end
          PM_WARM: begin
            if (cnt_q == LAST) begin
              st_q      <= PM_RUN;
              vec_fetch <= 1'b1;
              cnt_q     <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: st_q <= PM_RUN;
        endcase
      end
    end
  end

  assert_light_exit_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q == PM_IDLE && light_hit && !rst_any) |=> (vec_fetch && core_clk_en));

  assert_deep_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == PM_STOP && !deep_hit && !rst_any) |=> (st_q == PM_STOP));

  assert_warm_bound_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == PM_WARM) |-> (cnt_q <= LAST));

  assert_reset_exit_R8: assert property (@(posedge clk) disable iff (rst)
    rst_any |=> (st_q == PM_RUN && !vec_fetch));

  assert_fetch_running_R7: assert property (@(posedge clk) disable iff (rst)
    vec_fetch |-> (core_clk_en && periph_clk_en && osc_amp_en));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int NIRQ     = 6,
  parameter int NRST     = 3,
  parameter int WAKE_DLY = 16,
  parameter int IDW      = $clog2(NIRQ + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [7:0]      sfr_addr,
  input  logic            sfr_wr,
  input  logic [7:0]      sfr_wdata,
  output logic [7:0]      sfr_rdata,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_nonclk,
  input  logic            pfail_irq,
  input  logic            bandgap_en,
  input  logic [NRST-1:0] rst_src,
  output logic            core_clk_en,
  output logic            periph_clk_en,
  output logic            osc_amp_en,
  output logic            core_rst,
  output logic            vec_fetch,
  output logic [IDW-1:0]  wake_id
);
  logic           light_q, deep_q, clr_w, rst_any;
  logic           light_hit, deep_hit;
  logic [IDW-1:0] light_id, deep_id;

  assign rst_any = |rst_src;

  lpm_modereg #(.AW(8), .DW(8)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .run_i     (core_clk_en),
    .clr_i     (clr_w),
    .sfr_addr  (sfr_addr),
    .sfr_wr    (sfr_wr),
    .sfr_wdata (sfr_wdata),
    .sfr_rdata (sfr_rdata),
    .light_q   (light_q),
    .deep_q    (deep_q)
  );

  lpm_wakequal #(.NIRQ(NIRQ), .IDW(IDW)) u_qual (
    .irq_req    (irq_req),
    .irq_nonclk (irq_nonclk),
    .pfail_irq  (pfail_irq),
    .bandgap_en (bandgap_en),
    .light_hit  (light_hit),
    .deep_hit   (deep_hit),
    .light_id   (light_id),
    .deep_id    (deep_id)
  );

  lpm_seq #(.IDW(IDW), .WAKE_DLY(WAKE_DLY)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .light_q       (light_q),
    .deep_q        (deep_q),
    .rst_any       (rst_any),
    .light_hit     (light_hit),
    .deep_hit      (deep_hit),
    .light_id      (light_id),
    .deep_id       (deep_id),
    .clr_o         (clr_w),
    .core_clk_en   (core_clk_en),
    .periph_clk_en (periph_clk_en),
    .osc_amp_en    (osc_amp_en),
    .core_rst      (core_rst),
    .vec_fetch     (vec_fetch),
    .wake_id       (wake_id)
  );
endmodule

// File: tb/sim_lpm_ctrl.sv
module sim_lpm_ctrl;
  localparam int NIRQ = 6;
  localparam int NRST = 3;
  localparam int DLY  = 5;
  localparam int IDW  = $clog2(NIRQ + 1);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [7:0]      sfr_addr = 8'h87;
  logic            sfr_wr = 1'b0;
  logic [7:0]      sfr_wdata = 8'h00;
  logic [7:0]      sfr_rdata;
  logic [NIRQ-1:0] irq_req = '0;
  logic [NIRQ-1:0] irq_nonclk = '0;
  logic            pfail_irq = 1'b0;
  logic            bandgap_en = 1'b0;
  logic [NRST-1:0] rst_src = '0;
  logic            core_clk_en, periph_clk_en, osc_amp_en, core_rst, vec_fetch;
  logic [IDW-1:0]  wake_id;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lpm_ctrl #(.NIRQ(NIRQ), .NRST(NRST), .WAKE_DLY(DLY)) u0 (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .irq_req(irq_req),
    .irq_nonclk(irq_nonclk), .pfail_irq(pfail_irq), .bandgap_en(bandgap_en),
    .rst_src(rst_src), .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
    .osc_amp_en(osc_amp_en), .core_rst(core_rst), .vec_fetch(vec_fetch),
    .wake_id(wake_id)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clocks(input string req, input int core, input int per, input int osc);
    chk(req, "core_clk_en", int'(core_clk_en), core);
    chk(req, "periph_clk_en", int'(periph_clk_en), per);
    chk(req, "osc_amp_en", int'(osc_amp_en), osc);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    step(1);
    sfr_wr = 1'b0; sfr_addr = 8'h87;
  endtask

  task automatic go_deep();
    wr(8'h87, 8'h02);
    step(1);
  endtask

  task automatic t_reset();
    step(3);
    rst = 1'b0;
    step(1);
    clocks("R1", 1, 1, 1);
    chk("R1", "vec_fetch", int'(vec_fetch), 0);
    chk("R1", "core_rst", int'(core_rst), 0);
    chk("R1", "rdata", int'(sfr_rdata), 0);
  endtask

  task automatic t_light_wake();
    wr(8'h87, 8'h01);
    clocks("R2", 1, 1, 1);
    step(1);
    clocks("R2", 0, 1, 1);
    chk("R2", "rdata", int'(sfr_rdata), 1);
    irq_req = 6'b001100;
    step(1);
    irq_req = '0;
    chk("R4", "core_clk_en", int'(core_clk_en), 1);
    chk("R4", "vec_fetch", int'(vec_fetch), 1);
    chk("R4", "wake_id", int'(wake_id), 2);
    step(1);
    chk("R4", "vec_fetch pulse", int'(vec_fetch), 0);
    chk("R4", "rdata cleared", int'(sfr_rdata), 0);
    wr(8'h87, 8'h01);
    step(1);
    pfail_irq = 1'b1; bandgap_en = 1'b0;
    step(1);
    pfail_irq = 1'b0;
    chk("R4", "pfail light wake", int'(core_clk_en), 1);
    chk("R4", "pfail id", int'(wake_id), NIRQ);
    step(1);
  endtask

  task automatic t_deep_ignore();
    wr(8'h87, 8'h03);
    step(1);
    clocks("R3", 0, 0, 0);
    chk("R3", "rdata both set", int'(sfr_rdata), 2);
    irq_req = 6'b000011; irq_nonclk = 6'b111100;
    step(4);
    clocks("R5", 0, 0, 0);
    chk("R5", "vec_fetch", int'(vec_fetch), 0);
    chk("R5", "rdata", int'(sfr_rdata), 2);
    irq_req = '0;
    pfail_irq = 1'b1; bandgap_en = 1'b0;
    step(3);
    chk("R6", "osc without bandgap", int'(osc_amp_en), 0);
    bandgap_en = 1'b1;
    step(1);
    pfail_irq = 1'b0;
    chk("R6", "osc with bandgap", int'(osc_amp_en), 1);
    chk("R7", "core gated warm", int'(core_clk_en), 0);
    step(DLY - 1);
    chk("R7", "core still gated", int'(core_clk_en), 0);
    chk("R7", "periph still gated", int'(periph_clk_en), 0);
    step(1);
    clocks("R7", 1, 1, 1);
    chk("R7", "vec_fetch", int'(vec_fetch), 1);
    chk("R6", "wake_id", int'(wake_id), NIRQ);
    step(1);
    chk("R7", "vec_fetch pulse", int'(vec_fetch), 0);
    bandgap_en = 1'b0;
  endtask

  task automatic t_deep_wake();
    go_deep();
    irq_req = 6'b010010; irq_nonclk = 6'b010000;
    step(1);
    irq_req = '0;
    chk("R7", "osc on", int'(osc_amp_en), 1);
    step(DLY - 1);
    chk("R7", "core gated", int'(core_clk_en), 0);
    step(1);
    chk("R7", "core on", int'(core_clk_en), 1);
    chk("R7", "vec_fetch", int'(vec_fetch), 1);
    chk("R7", "wake_id", int'(wake_id), 4);
    chk("R7", "rdata", int'(sfr_rdata), 0);
    step(1);
  endtask

  task automatic t_reset_src();
    wr(8'h87, 8'h01);
    step(1);
    rst_src = 3'b010;
    step(1);
    rst_src = '0;
    clocks("R8", 1, 1, 1);
    chk("R8", "core_rst", int'(core_rst), 1);
    chk("R8", "vec_fetch", int'(vec_fetch), 0);
    step(1);
    chk("R8", "core_rst release", int'(core_rst), 0);
    chk("R8", "rdata", int'(sfr_rdata), 0);
    go_deep();
    rst_src = 3'b100;
    step(1);
    rst_src = '0;
    clocks("R8", 1, 1, 1);
    step(1);
    chk("R8", "deep rdata", int'(sfr_rdata), 0);
    step(2);
    clocks("R8", 1, 1, 1);
  endtask

  task automatic t_ignored();
    wr(8'h88, 8'h03);
    step(2);
    clocks("R9", 1, 1, 1);
    chk("R9", "rdata 87", int'(sfr_rdata), 0);
    sfr_addr = 8'h88;
    step(1);
    chk("R10", "other address", int'(sfr_rdata), 0);
    sfr_addr = 8'h87;
    wr(8'h87, 8'h01);
    step(1);
    wr(8'h87, 8'h02);
    step(2);
    clocks("R9", 0, 1, 1);
    chk("R9", "rdata light", int'(sfr_rdata), 1);
    sfr_addr = 8'h40;
    step(1);
    chk("R10", "other address", int'(sfr_rdata), 0);
    sfr_addr = 8'h87;
    step(1);
    chk("R10", "back at 87h", int'(sfr_rdata), 1);
    irq_req = 6'b100000;
    step(1);
    irq_req = '0;
    chk("R4", "wake_id top bit", int'(wake_id), 5);
    step(1);
  endtask

  initial begin
    t_reset();
    t_light_wake();
    t_deep_ignore();
    t_deep_wake();
    t_reset_src();
    t_ignored();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule